// File: doc/BRIEF.md
# PCM Bit-Clock and Frame-Sync Generator

This block times a serial voice link. As master, it derives a bit clock from the fast system clock and cuts the bit stream into frames with a sync signal. As slave, it takes both signals from outside and passes them straight through. In either mode it gives the neighbouring data path a one-cycle strobe for each bit-clock rise and a one-cycle strobe when a frame begins.

Two ways of making the bit clock are offered. A fixed divider gives one of three standard rates. A fractional accumulator adds a programmable step on every system clock and wraps at a programmable limit. The sync can be long, where a rising edge opens the frame and the pulse lasts 8 or 16 bits. It can also be short, where a one-bit pulse whose falling edge opens the frame is used. Sync can be held low while the clock keeps running, so that an attached codec can drop into a low-power state.

Top module: `pcm_clkgen`

## Requirements
- R1: While `rst` is high at a clock edge and the block is master, `pcmClk`, `pcmSync`, `bitRise` and `frameStart` are low after that edge.
- R2: With `fastGenEn`=0, `rateSel` picks the bit-clock half period in system clocks: 2'b01 gives SYS_HZ/256000 (128 kHz), 2'b00 gives SYS_HZ/512000 (256 kHz), 2'b10 gives SYS_HZ/1024000 (512 kHz), and 2'b11 behaves as 2'b00. The first rise follows one half period after reset.
- R3: With `fastGenEn`=1, an accumulator adds `cntRate` on each system clock. When the sum reaches `cntLimit`, the limit is subtracted and `pcmClk` toggles. A `cntRate` above `cntLimit` counts as `cntLimit`, so the clock toggles every cycle. A `cntLimit` of 0 stops the clock.
- R4: A master frame lasts `frameDiv`+1 bit clocks. `frameStart` is high for one system cycle, in the same cycle in which `pcmClk` rises on the first bit of a frame. The first rise after reset opens a frame.
- R5: With `shortSync`=0, `pcmSync` rises with the frame's first bit. It stays high for 8 bit clocks when `longLen`=0 and for 16 when `longLen`=1.
- R6: With `shortSync`=1, `pcmSync` is high for the last bit of each frame only and falls as the next frame starts. `longLen` has no effect.
- R7: As master with `syncOff`=1, `pcmSync` stays low while `pcmClk`, `bitRise` and `frameStart` continue unchanged.
- R8: With `slaveMode`=1, `pcmClk` equals `extBclk` and `pcmSync` equals `extSync` without delay. `frameStart` pulses in the cycle after a system edge that first sees `extBclk` high, if the `extSync` value sampled there forms the start edge against the value sampled at the previous bit-clock rise: a rise for long sync, a fall for short sync.
- R9: `bitRise` is high for exactly the system cycles in which `pcmClk` has just gone from low to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| slaveMode | input | 1 | 1: take clock and sync from outside |
| fastGenEn | input | 1 | 1: accumulator generation, 0: fixed divider |
| rateSel | input | 2 | Fixed-divider rate code |
| cntRate | input | ACC_W | Accumulator step per system clock |
| cntLimit | input | ACC_W | Accumulator wrap limit |
| shortSync | input | 1 | 1: short sync, 0: long sync |
| longLen | input | 1 | Long-sync length, 0: 8 bits, 1: 16 bits |
| syncOff | input | 1 | 1: hold master sync low |
| frameDiv | input | FRAME_W | Frame length in bit clocks minus one |
| extBclk | input | 1 | External bit clock (slave) |
| extSync | input | 1 | External frame sync (slave) |
| pcmClk | output | 1 | Bit clock |
| pcmSync | output | 1 | Frame sync |
| bitRise | output | 1 | One-cycle strobe on each bit-clock rise |
| frameStart | output | 1 | One-cycle strobe at the start of a frame |

## Verification
A corrupted divider or accumulator shows at once as a wrong count of `pcmClk` transitions over a fixed window. Each toggle lands within one half period of where it should, so the error is visible within a few dozen system cycles. A wrong bit counter shows as a `frameStart` that is missing or in the wrong place, or as a sync pulse of the wrong width, within one frame (256 system cycles in the frame tests). A bad slave edge detector shows as a strobe that is missing or extra on the bit after the external sync moves.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  // Rate codes of the fixed divider; the 2'b11 code falls back to 256 kHz.
  typedef enum logic [1:0] {
    RATE_256K = 2'b00,
    RATE_128K = 2'b01,
    RATE_512K = 2'b10,
    RATE_ALT  = 2'b11
  } pcm_rate_e;

  // Strobes handed from the timing control to the frame datapath.
  typedef struct packed {
    logic rise;    // bit clock goes high at this edge
    logic master;  // clock and sync are generated inside
  } pcm_tick_t;

endpackage

// File: rtl/pcm_clkgen_ctrl.sv
module pcm_clkgen_ctrl
  import pcm_clkgen_pkg::*;
#(
  parameter int SYS_HZ = 4096000,
  parameter int ACC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slaveMode,
  input  logic             fastGenEn,
  input  logic [1:0]       rateSel,
  input  logic [ACC_W-1:0] cntRate,
  input  logic [ACC_W-1:0] cntLimit,
  input  logic             extBclk,
  output logic             bclkQ,
  output logic             bitRise,
  output pcm_tick_t        tick
);

  localparam int HALF_128 = (SYS_HZ / 256000  > 0) ? SYS_HZ / 256000  : 1;
  localparam int HALF_256 = (SYS_HZ / 512000  > 0) ? SYS_HZ / 512000  : 1;
  localparam int HALF_512 = (SYS_HZ / 1024000 > 0) ? SYS_HZ / 1024000 : 1;
  localparam int DIV_W    = $clog2(HALF_128 + 1);

  // fixed divider
  logic [DIV_W-1:0] divCnt, halfSel;
  logic             fixedHit;

  always_comb begin
    case (pcm_rate_e'(rateSel))
      RATE_128K: halfSel = DIV_W'(HALF_128);
      RATE_512K: halfSel = DIV_W'(HALF_512);
      default:   halfSel = DIV_W'(HALF_256);
    endcase
    fixedHit = (divCnt >= halfSel - 1'b1);
  end

  // fractional accumulator
  logic [ACC_W-1:0] acc, effRate, accNext;
  logic [ACC_W:0]   sum;
  logic             fastHit;

  always_comb begin
    effRate = (cntRate > cntLimit) ? cntLimit : cntRate;
    sum     = {1'b0, acc} + {1'b0, effRate};
    fastHit = (cntLimit != '0) && (sum >= {1'b0, cntLimit});
    if (cntLimit == '0)
      accNext = '0;
    else if (fastHit)
      accNext = ACC_W'(sum - {1'b0, cntLimit});
    else
      accNext = sum[ACC_W-1:0];
  end

  logic toggle;
  always_comb begin
    if (slaveMode)
      toggle = (extBclk != bclkQ);
    else if (fastGenEn)
      toggle = fastHit;
    else
      toggle = fixedHit;
    tick.rise   = toggle & ~bclkQ;
    tick.master = ~slaveMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclkQ   <= 1'b0;
      bitRise <= 1'b0;
      divCnt  <= '0;
      acc     <= '0;
    end else begin
      bclkQ   <= bclkQ ^ toggle;
      bitRise <= tick.rise;
      if (slaveMode || fastGenEn)
        divCnt <= '0;
      else if (fixedHit)
        divCnt <= '0;
      else
        divCnt <= divCnt + 1'b1;
      if (slaveMode || !fastGenEn)
        acc <= '0;
      else
        acc <= accNext;
    end
  end

  AST_RISE_MARKS_CLK: assert property (@(posedge clk) disable iff (rst)
    bitRise |-> (bclkQ && !$past(bclkQ))); // R9

  AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (!slaveMode && fastGenEn && cntLimit != '0 && $past(cntLimit) == cntLimit
     && $past(!slaveMode && fastGenEn) && $past(acc) < cntLimit)
    |-> (acc < cntLimit)); // R3

endmodule

// File: rtl/pcm_clkgen_dp.sv
module pcm_clkgen_dp
  import pcm_clkgen_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  pcm_tick_t          tick,
  input  logic               shortSync,
  input  logic               longLen,
  input  logic [FRAME_W-1:0] frameDiv,
  input  logic               extSync,
  output logic               syncReg,
  output logic               frameStart
);

  logic [FRAME_W-1:0] bitCnt, nextBit;
  logic               running;
  logic               extSyncQ;
  logic               genSyncNext;
  logic               extStart;

  always_comb begin
    nextBit = (!running || bitCnt >= frameDiv) ? '0 : bitCnt + 1'b1;
    if (shortSync)
      genSyncNext = (nextBit == frameDiv);
    else
      genSyncNext = (int'(nextBit) < (longLen ? 16 : 8));
    extStart = shortSync ? (!extSync && extSyncQ) : (extSync && !extSyncQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt     <= '0;
      running    <= 1'b0;
      syncReg    <= 1'b0;
      extSyncQ   <= 1'b0;
      frameStart <= 1'b0;
    end else if (tick.rise) begin
      if (tick.master) begin
        bitCnt     <= nextBit;
        running    <= 1'b1;
        syncReg    <= genSyncNext;
        frameStart <= (nextBit == '0);
      end else begin
        running    <= 1'b0;
        syncReg    <= 1'b0;
        extSyncQ   <= extSync;
        frameStart <= extStart;
      end
    end else begin
      frameStart <= 1'b0;
    end
  end

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> $past(tick.rise)); // R4

  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (tick.master && $past(tick.master) && $stable(frameDiv) && $past(bitCnt) <= frameDiv)
    |-> (bitCnt <= frameDiv)); // R4

  AST_LONG_SYNC_OPENS: assert property (@(posedge clk) disable iff (rst)
    (frameStart && tick.master && !shortSync && $past(tick.master && !shortSync))
    |-> syncReg); // R5

  AST_SHORT_SYNC_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (frameStart && tick.master && shortSync && frameDiv != '0
     && $past(tick.master && shortSync) && $stable(frameDiv))
    |-> !syncReg); // R6

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_clkgen_pkg::*;
#(
  parameter int SYS_HZ  = 4096000,
  parameter int ACC_W   = 16,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slaveMode,
  input  logic               fastGenEn,
  input  logic [1:0]         rateSel,
  input  logic [ACC_W-1:0]   cntRate,
  input  logic [ACC_W-1:0]   cntLimit,
  input  logic               shortSync,
  input  logic               longLen,
  input  logic               syncOff,
  input  logic [FRAME_W-1:0] frameDiv,
  input  logic               extBclk,
  input  logic               extSync,
  output logic               pcmClk,
  output logic               pcmSync,
  output logic               bitRise,
  output logic               frameStart
);

  pcm_tick_t tick;
  logic      bclkQ;
  logic      syncReg;

  pcm_clkgen_ctrl #(.SYS_HZ(SYS_HZ), .ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst(rst), .slaveMode(slaveMode), .fastGenEn(fastGenEn),
    .rateSel(rateSel), .cntRate(cntRate), .cntLimit(cntLimit),
    .extBclk(extBclk), .bclkQ(bclkQ), .bitRise(bitRise), .tick(tick)
  );

  pcm_clkgen_dp #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rst(rst), .tick(tick), .shortSync(shortSync),
    .longLen(longLen), .frameDiv(frameDiv), .extSync(extSync),
    .syncReg(syncReg), .frameStart(frameStart)
  );

  assign pcmClk  = slaveMode ? extBclk : bclkQ;
  assign pcmSync = slaveMode ? extSync : (syncReg & ~syncOff);

  AST_SUPPRESS_KEEPS_FRAMING: assert property (@(posedge clk) disable iff (rst)
    (!slaveMode && frameStart) |-> (pcmClk && bitRise)); // R7

endmodule

// File: tb/pcm_clkgen_test.sv
`timescale 1ns/1ps
module pcm_clkgen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slaveMode = 1'b0, fastGenEn = 1'b0;
  logic [1:0]  rateSel = 2'b10;
  logic [15:0] cntRate = 16'd1, cntLimit = 16'd1;
  logic        shortSync = 1'b0, longLen = 1'b0, syncOff = 1'b0;
  logic [7:0]  frameDiv = 8'd31;
  logic        extBclk = 1'b0, extSync = 1'b0;
  logic        pcmClk, pcmSync, bitRise, frameStart;

  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  pcm_clkgen uut (
    .clk(clk), .rst(rst), .slaveMode(slaveMode), .fastGenEn(fastGenEn),
    .rateSel(rateSel), .cntRate(cntRate), .cntLimit(cntLimit),
    .shortSync(shortSync), .longLen(longLen), .syncOff(syncOff),
    .frameDiv(frameDiv), .extBclk(extBclk), .extSync(extSync),
    .pcmClk(pcmClk), .pcmSync(pcmSync), .bitRise(bitRise), .frameStart(frameStart)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  int clkEdges, syncHigh, fsCount, fsFirst, fsSecond, riseBad, syncAtFs, syncPrevFs;

  task automatic observe(input int n, input int syncWin);
    logic pc = 1'b0, ps = 1'b0;
    clkEdges = 0; syncHigh = 0; fsCount = 0; fsFirst = -1; fsSecond = -1;
    riseBad = 0; syncAtFs = -1; syncPrevFs = -1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (pcmClk != pc) clkEdges++;
      if (bitRise != (pcmClk && !pc)) riseBad++;
      if (k <= syncWin && pcmSync) syncHigh++;
      if (frameStart) begin
        if (fsCount == 0) fsFirst = k;
        if (fsCount == 1) fsSecond = k;
        fsCount++;
        syncAtFs = int'(pcmSync);
        syncPrevFs = int'(ps);
      end
      pc = pcmClk;
      ps = pcmSync;
    end
  endtask

  task automatic testReset();
    slaveMode = 0; fastGenEn = 1; cntRate = 1; cntLimit = 1;
    @(negedge clk) rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(pcmClk == 0, "R1 pcmClk in reset", pcmClk, 0);
    chk(pcmSync == 0, "R1 pcmSync in reset", pcmSync, 0);
    chk(bitRise == 0, "R1 bitRise in reset", bitRise, 0);
    chk(frameStart == 0, "R1 frameStart in reset", frameStart, 0);
  endtask

  task automatic testFixedRates();
    fastGenEn = 0; frameDiv = 31;
    rateSel = 2'b01; applyReset(); observe(64, 0);
    chk(clkEdges == 4, "R2 128k transitions", clkEdges, 4);
    rateSel = 2'b00; applyReset(); observe(64, 0);
    chk(clkEdges == 8, "R2 256k transitions", clkEdges, 8);
    rateSel = 2'b10; applyReset(); observe(64, 0);
    chk(clkEdges == 16, "R2 512k transitions", clkEdges, 16);
    rateSel = 2'b11; applyReset(); observe(64, 0);
    chk(clkEdges == 8, "R2 code 11 transitions", clkEdges, 8);
  endtask

  task automatic testFastGen();
    fastGenEn = 1;
    cntRate = 3; cntLimit = 8; applyReset(); observe(24, 0);
    chk(clkEdges == 9, "R3 rate 3 limit 8", clkEdges, 9);
    cntRate = 20; cntLimit = 8; applyReset(); observe(24, 0);
    chk(clkEdges == 24, "R3 rate above limit", clkEdges, 24);
    cntRate = 5; cntLimit = 0; applyReset(); observe(24, 0);
    chk(clkEdges == 0, "R3 zero limit", clkEdges, 0);
    fastGenEn = 0;
  endtask

  task automatic testLongSync();
    fastGenEn = 0; rateSel = 2'b10; frameDiv = 31; shortSync = 0; syncOff = 0;
    longLen = 0; applyReset(); observe(300, 259);
    chk(fsFirst == 4, "R4 first frame start", fsFirst, 4);
    chk(fsSecond == 260, "R4 second frame start", fsSecond, 260);
    chk(fsCount == 2, "R4 frame start count", fsCount, 2);
    chk(syncHigh == 64, "R5 long sync 8 bits", syncHigh, 64);
    chk(syncAtFs == 1, "R5 sync high at start", syncAtFs, 1);
    chk(syncPrevFs == 0, "R5 sync low before start", syncPrevFs, 0);
    chk(riseBad == 0, "R9 bitRise alignment", riseBad, 0);
    longLen = 1; applyReset(); observe(300, 259);
    chk(syncHigh == 128, "R5 long sync 16 bits", syncHigh, 128);
    longLen = 0;
  endtask

  task automatic testShortSync();
    fastGenEn = 0; rateSel = 2'b10; frameDiv = 31; shortSync = 1; syncOff = 0;
    for (int l = 0; l < 2; l++) begin
      longLen = l[0];
      applyReset(); observe(300, 259);
      chk(syncHigh == 8, "R6 short sync one bit", syncHigh, 8);
      chk(syncPrevFs == 1, "R6 sync high before start", syncPrevFs, 1);
      chk(syncAtFs == 0, "R6 sync falls at start", syncAtFs, 0);
    end
    shortSync = 0; longLen = 0;
  endtask

  task automatic testSuppress();
    fastGenEn = 0; rateSel = 2'b10; frameDiv = 31; shortSync = 0; syncOff = 1;
    applyReset(); observe(300, 300);
    chk(syncHigh == 0, "R7 sync held low", syncHigh, 0);
    chk(clkEdges == 75, "R7 clock keeps running", clkEdges, 75);
    chk(fsCount == 2, "R7 frame starts continue", fsCount, 2);
    chk(riseBad == 0, "R7 bitRise continues", riseBad, 0);
    syncOff = 0;
  endtask

  task automatic slaveBit(input logic s, output int fs);
    @(negedge clk);
    extBclk = 1'b0; extSync = s;
    repeat (3) @(negedge clk);
    extBclk = 1'b1;
    @(negedge clk);
    fs = int'(frameStart);
  endtask

  task automatic testSlave();
    int fs;
    slaveMode = 1; shortSync = 0; syncOff = 1;
    applyReset();
    @(negedge clk);
    extBclk = 1; extSync = 0; #1;
    chk(pcmClk == 1, "R8 clock passthrough", pcmClk, 1);
    chk(pcmSync == 0, "R8 sync passthrough low", pcmSync, 0);
    extSync = 1; #1;
    chk(pcmSync == 1, "R8 sync passthrough ignores syncOff", pcmSync, 1);
    extBclk = 0; #1;
    chk(pcmClk == 0, "R8 clock passthrough low", pcmClk, 0);
    syncOff = 0;
    applyReset();
    slaveBit(0, fs); chk(fs == 0, "R8 long no start", fs, 0);
    slaveBit(1, fs); chk(fs == 1, "R8 long start on rise", fs, 1);
    @(negedge clk); chk(frameStart == 0, "R8 strobe one cycle", frameStart, 0);
    slaveBit(1, fs); chk(fs == 0, "R8 long held high", fs, 0);
    shortSync = 1; applyReset();
    slaveBit(1, fs); chk(fs == 0, "R8 short sync high", fs, 0);
    slaveBit(0, fs); chk(fs == 1, "R8 short start on fall", fs, 1);
    slaveBit(0, fs); chk(fs == 0, "R8 short held low", fs, 0);
    slaveMode = 0; shortSync = 0; extBclk = 0; extSync = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1500000;
    compared++;
    mismatched++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    testReset();
    testFixedRates();
    testFastGen();
    testLongSync();
    testShortSync();
    testSuppress();
    testSlave();
    finishRun();
  end

endmodule